// File: doc/BRIEF.md
# MDIO Management Master (Clause 22 / Clause 45)

This block is a station-management master for copper and optical PHYs. It generates the management clock (MDC) and drives or releases a shared, tri-stated MDIO line. A host programs it through a 32-bit word-addressed register port that holds four registers. Writing one of those registers is what launches a serial frame on the management bus.

A configuration bit selects between the short-address frame format (Clause 22) and the extended format (Clause 45). In the extended format an indirect register access takes two frames. Writing the address register sends an address frame that latches the target register inside the PHY. A later write or read frame then moves the data. Writing the data register launches a write frame. Writing the control register with its read bit set launches a read frame. The read value lands in the data register and can be fetched once the data-busy flag drops.

The block keeps two busy indications. The status busy bit covers any frame on the wire. The data-register busy bit covers only read and write transfers. A read whose second turnaround bit is not pulled low by the PHY sets a sticky read-error flag. Software then treats the returned value as all ones.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, status busy (status bit 0), read error (status bit 1) and data busy (data bit 31) are all 0. The divider field (status bits 15:8) holds RST_DIV, and MDC is low.
- R2: Register word indices are 12 for status, 13 for control, 14 for data and 15 for address. Reads of any other index return 0. The status register holds the format select in bit 6 (1 = Clause 45) and the divider in bits 15:8. The control register holds the device/register field in bits 4:0, the PHY address in bits 9:5, preamble disable in bit 10, post-increment in bit 14 and read start in bit 15. The data register holds its value in bits 15:0.
- R3: Writing the data register in Clause 22 mode sends 32 ones of preamble and then the 32-bit frame: start 01, opcode 01, PHY address (MSB first), register field, turnaround 10, 16 data bits MSB first.
- R4: A Clause 22 read (control bit 15 set) sends start 01 and opcode 10 plus the two address fields. The master releases MDIO from the first turnaround bit to the end of the frame and shifts the 16 sampled bits, MSB first, into the data register.
- R5: In Clause 45 mode a write to the address register sends an address frame: start 00, opcode 00, turnaround 10, then the 16-bit address. In Clause 22 mode the same write only stores the value and sends no frame.
- R6: In Clause 45 mode a data write uses opcode 01. A read uses opcode 11, or opcode 10 when post-increment (control bit 14) is set.
- R7: With preamble disable set, the frame starts directly with the start bits, with no leading ones.
- R8: MDIO output and output enable change only on a falling MDC edge, or when a frame starts. The PHY's bits are sampled on the rising edge.
- R9: If MDIO is high at the second turnaround bit of a read, status bit 1 becomes 1. The next read launch clears it.
- R10: Data bit 31 is 1 from the launch of a read or write frame until it ends, and it stays 0 during an address frame. Status bit 0 is 1 during any frame.
- R11: Register writes that arrive while a frame is pending or in progress have no effect.
- R12: While a frame runs, MDC toggles every (divider+1) system clocks. MDC stays low when the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | ADDR_W | Word index of the host register |
| regWrEn | input | 1 | Host write strobe, one cycle per write |
| regWrData | input | 32 | Host write data |
| regRdData | output | 32 | Host read data for regAddr (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Value driven onto MDIO when enabled |
| mdioOe | output | 1 | MDIO output enable (1 = master drives) |
| mdioIn | input | 1 | Resolved MDIO line level |

## Verification
The hardest case to reach from the ports is the read error, because the PHY has to leave the line floating exactly at the second turnaround bit. The bench's PHY model tracks each frame from the driven header bits. For a read it either answers, pulling the turnaround low and then shifting out a chosen word, or stays silent so that the pull-up leaves the line high. A successful read follows and must clear the flag. Register writes that should be ignored are issued during a running frame, and the control register is read back after that frame ends.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int IDX_STAT = 12;
  localparam int IDX_CTRL = 13;
  localparam int IDX_DATA = 14;
  localparam int IDX_ADDR = 15;
  localparam int FRAME_BITS = 32;
  localparam int HDR_BITS = 14;

  typedef enum logic [1:0] {
    K_ADDR  = 2'd0,
    K_WRITE = 2'd1,
    K_READ  = 2'd2
  } frameKind_t;

  typedef struct packed {
    logic loadFrame;
    logic shiftOut;
    logic sampleTa;
    logic sampleData;
    logic clrErr;
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launchValid,
  input  frameKind_t       launchKind,
  input  logic             preDis,
  input  logic [DIV_W-1:0] divVal,
  output mdioStrobe_t      strobes,
  output logic             busBusy,
  output logic             dataBusy,
  output logic             mdc,
  output logic             mdioOe,
  output logic             inPreamble
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_FRAME} state_t;

  state_t           state;
  logic [CNT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic             isRead;
  logic             tick, rise, fall;

  assign tick = (state != ST_IDLE) && (divCnt == '0);
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      divCnt   <= '0;
      mdc      <= 1'b0;
      isRead   <= 1'b0;
      dataBusy <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (launchValid) begin
            state    <= preDis ? ST_FRAME : ST_PRE;
            bitCnt   <= '0;
            divCnt   <= divVal;
            mdc      <= 1'b0;
            isRead   <= (launchKind == K_READ);
            dataBusy <= (launchKind != K_ADDR);
          end
        end
        default: begin
          if (divCnt == '0) begin
            divCnt <= divVal;
            mdc    <= ~mdc;
            if (mdc) begin
              if (bitCnt == LAST_BIT) begin
                bitCnt <= '0;
                if (state == ST_PRE) begin
                  state <= ST_FRAME;
                end else begin
                  state    <= ST_IDLE;
                  dataBusy <= 1'b0;
                end
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt - 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobes.loadFrame  = (state == ST_IDLE) && launchValid;
    strobes.clrErr     = strobes.loadFrame && (launchKind == K_READ);
    strobes.shiftOut   = fall && (state == ST_FRAME) && (bitCnt != LAST_BIT);
    strobes.sampleTa   = rise && (state == ST_FRAME) && isRead &&
                         (bitCnt == CNT_W'(HDR_BITS + 1));
    strobes.sampleData = rise && (state == ST_FRAME) && isRead &&
                         (bitCnt >= CNT_W'(HDR_BITS + 2));
  end

  assign busBusy    = (state != ST_IDLE);
  assign inPreamble = (state == ST_PRE);
  assign mdioOe     = (state == ST_PRE) ||
                      ((state == ST_FRAME) && (!isRead || bitCnt < CNT_W'(HDR_BITS)));

  // checker counter: cycles since the last MDC change
  logic [DIV_W:0] sinceToggle;
  always_ff @(posedge clk) begin
    if (rst || state == ST_IDLE || tick) sinceToggle <= '0;
    else sinceToggle <= sinceToggle + 1'b1;
  end

  a_r12_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !mdc);
  a_r12_half_period: assert property (@(posedge clk) disable iff (rst)
    busBusy |-> (sinceToggle <= {1'b0, divVal}));
  a_r10_data_within_bus: assert property (@(posedge clk) disable iff (rst)
    dataBusy |-> busBusy);
  a_r8_oe_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdioOe) |-> ($fell(mdc) || $past(state == ST_IDLE)));
  a_r4_sample_released: assert property (@(posedge clk) disable iff (rst)
    (strobes.sampleData || strobes.sampleTa) |-> !mdioOe);
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int              ADDR_W  = 4,
  parameter int              DIV_W   = 8,
  parameter logic [DIV_W-1:0] RST_DIV = 8'd4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  mdioStrobe_t       strobes,
  input  logic              busBusy,
  input  logic              dataBusy,
  input  logic              mdioIn,
  output logic              launchValid,
  output frameKind_t        launchKind,
  output logic              preDis,
  output logic [DIV_W-1:0]  divVal,
  output logic              frameBit
);
  logic        c45Sel, postInc, rdErr;
  logic [4:0]  devAd, portAd;
  logic [15:0] dataReg, addrReg;
  logic [31:0] shiftReg;
  logic        wrOk;
  logic [1:0]  stCode, opCode;
  logic [15:0] payload;

  assign wrOk = regWrEn && !busBusy && !launchValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      c45Sel      <= 1'b0;
      divVal      <= RST_DIV;
      devAd       <= '0;
      portAd      <= '0;
      preDis      <= 1'b0;
      postInc     <= 1'b0;
      dataReg     <= '0;
      addrReg     <= '0;
      rdErr       <= 1'b0;
      launchValid <= 1'b0;
      launchKind  <= K_ADDR;
      shiftReg    <= '0;
    end else begin
      launchValid <= 1'b0;
      if (wrOk) begin
        if (regAddr == ADDR_W'(IDX_STAT)) begin
          c45Sel <= regWrData[6];
          divVal <= regWrData[8 +: DIV_W];
        end
        if (regAddr == ADDR_W'(IDX_CTRL)) begin
          devAd   <= regWrData[4:0];
          portAd  <= regWrData[9:5];
          preDis  <= regWrData[10];
          postInc <= regWrData[14];
          if (regWrData[15]) begin
            launchValid <= 1'b1;
            launchKind  <= K_READ;
          end
        end
        if (regAddr == ADDR_W'(IDX_DATA)) begin
          dataReg     <= regWrData[15:0];
          launchValid <= 1'b1;
          launchKind  <= K_WRITE;
        end
        if (regAddr == ADDR_W'(IDX_ADDR)) begin
          addrReg <= regWrData[15:0];
          if (c45Sel) begin
            launchValid <= 1'b1;
            launchKind  <= K_ADDR;
          end
        end
      end
      if (strobes.loadFrame) shiftReg <= {stCode, opCode, portAd, devAd, 2'b10, payload};
      else if (strobes.shiftOut) shiftReg <= {shiftReg[30:0], 1'b1};
      if (strobes.clrErr) rdErr <= 1'b0;
      else if (strobes.sampleTa && mdioIn) rdErr <= 1'b1;
      if (strobes.sampleData) dataReg <= {dataReg[14:0], mdioIn};
    end
  end

  always_comb begin
    stCode  = c45Sel ? 2'b00 : 2'b01;
    payload = (launchKind == K_ADDR) ? addrReg : dataReg;
    case (launchKind)
      K_WRITE: opCode = 2'b01;
      K_READ:  opCode = c45Sel ? (postInc ? 2'b10 : 2'b11) : 2'b10;
      default: opCode = 2'b00;
    endcase
  end

  assign frameBit = shiftReg[31];

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(IDX_STAT)) begin
      regRdData[8 +: DIV_W] = divVal;
      regRdData[6] = c45Sel;
      regRdData[1] = rdErr;
      regRdData[0] = busBusy | launchValid;
    end else if (regAddr == ADDR_W'(IDX_CTRL)) begin
      regRdData[14]  = postInc;
      regRdData[10]  = preDis;
      regRdData[9:5] = portAd;
      regRdData[4:0] = devAd;
    end else if (regAddr == ADDR_W'(IDX_DATA)) begin
      regRdData[31]   = dataBusy | (launchValid && launchKind != K_ADDR);
      regRdData[15:0] = dataReg;
    end else if (regAddr == ADDR_W'(IDX_ADDR)) begin
      regRdData[15:0] = addrReg;
    end
  end

  a_r11_ctrl_held: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && busBusy) |=> $stable({devAd, portAd, preDis, postInc, c45Sel, divVal}));
  a_r9_err_from_ta: assert property (@(posedge clk) disable iff (rst)
    $rose(rdErr) |-> $past(strobes.sampleTa));
  a_r3_no_shift_idle: assert property (@(posedge clk) disable iff (rst)
    !busBusy |-> !strobes.shiftOut);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int               ADDR_W  = 4,
  parameter int               DIV_W   = 8,
  parameter logic [DIV_W-1:0] RST_DIV = 8'd4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  mdioStrobe_t      strobes;
  frameKind_t       launchKind;
  logic             launchValid, preDis, busBusy, dataBusy, inPreamble, frameBit;
  logic [DIV_W-1:0] divVal;

  mdio_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rst(rst), .launchValid(launchValid), .launchKind(launchKind),
    .preDis(preDis), .divVal(divVal), .strobes(strobes), .busBusy(busBusy),
    .dataBusy(dataBusy), .mdc(mdc), .mdioOe(mdioOe), .inPreamble(inPreamble)
  );

  mdio_datapath #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .RST_DIV(RST_DIV)) uPath (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .strobes(strobes),
    .busBusy(busBusy), .dataBusy(dataBusy), .mdioIn(mdioIn),
    .launchValid(launchValid), .launchKind(launchKind), .preDis(preDis),
    .divVal(divVal), .frameBit(frameBit)
  );

  assign mdioOut = inPreamble ? 1'b1 : frameBit;
endmodule

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe, mdioIn;
  logic        phyOe = 1'b0, phyOut = 1'b1;
  int          checks = 0, failures = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;
  assign mdioIn = mdioOe ? mdioOut : (phyOe ? phyOut : 1'b1);

  mdio_mgmt_master u0 (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  typedef struct {
    logic [63:0] exp;
    int          n;
    bit          isRead;
    bit          answers;
    logic [15:0] resp;
    string       tag;
  } item_t;
  item_t q[$];

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(int idx, logic [31:0] val);
    @(negedge clk);
    regAddr = 4'(idx); regWrData = val; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic hostRead(int idx, output logic [31:0] val);
    @(negedge clk);
    regAddr = 4'(idx);
    #1 val = regRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      hostRead(12, s);
      if (!s[0]) return;
    end
    check(1'b0, "bus never went idle", 64'(s), 64'd0);
  endtask

  function automatic logic [31:0] mkFrame(logic [1:0] st, logic [1:0] op,
      logic [4:0] pa, logic [4:0] da, logic [15:0] pay);
    return {st, op, pa, da, 2'b10, pay};
  endfunction

  task automatic expectFrame(logic [31:0] fr, bit pre, string tag);
    item_t it;
    it.exp = pre ? {32'hFFFF_FFFF, fr} : {32'd0, fr};
    it.n = pre ? 64 : 32;
    it.isRead = 0; it.answers = 0; it.resp = '0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expectRead(logic [1:0] st, logic [1:0] op, logic [4:0] pa,
      logic [4:0] da, bit answers, logic [15:0] resp, string tag);
    item_t it;
    it.exp = {18'd0, 32'hFFFF_FFFF, st, op, pa, da};
    it.n = 46;
    it.isRead = 1; it.answers = answers; it.resp = resp; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor and PHY model: pops expectations and compares driven bits
  initial begin
    item_t it;
    logic [63:0] cap;
    int k;
    forever begin
      while (q.size() == 0) @(posedge clk);
      it = q.pop_front();
      cap = '0; k = 0;
      while (k < it.n) begin
        @(posedge mdc);
        if (mdioOe) begin
          cap = {cap[62:0], mdioOut};
          k++;
        end
      end
      check(cap == it.exp, it.tag, cap, it.exp);
      if (it.isRead) begin
        @(negedge mdc); phyOe = 1'b0;
        @(negedge mdc);
        if (it.answers) begin phyOe = 1'b1; phyOut = 1'b0; end
        for (int i = 15; i >= 0; i--) begin
          @(negedge mdc);
          if (it.answers) phyOut = it.resp[i];
        end
        @(negedge mdc); phyOe = 1'b0; phyOut = 1'b1;
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    time t0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    hostRead(12, v);
    check(v == 32'h0000_0400, "R1 status after reset", 64'(v), 64'h400);
    hostRead(14, v);
    check(v[31] == 1'b0, "R1 data busy after reset", 64'(v[31]), 64'd0);
    check(mdc == 1'b0, "R1/R12 mdc low after reset", 64'(mdc), 64'd0);
    hostRead(3, v);
    check(v == 32'd0, "R2 unmapped index reads zero", 64'(v), 64'd0);

    // R2 set divider = 1, Clause 22
    hostWrite(12, 32'h0000_0100);
    hostRead(12, v);
    check(v == 32'h0000_0100, "R2 status readback", 64'(v), 64'h100);

    // R3 Clause 22 write, R10 busy flags, R11 ignored write, R12 period
    hostWrite(13, {22'd0, 5'd5, 5'd3});
    expectFrame(mkFrame(2'b01, 2'b01, 5'd5, 5'd3, 16'hA5C3), 1, "R3 c22 write frame");
    hostWrite(14, 32'h0000_A5C3);
    hostRead(14, v);
    check(v[31] == 1'b1, "R10 data busy during write", 64'(v[31]), 64'd1);
    hostRead(12, v);
    check(v[0] == 1'b1, "R10 status busy during write", 64'(v[0]), 64'd1);
    hostWrite(13, {22'd0, 5'd31, 5'd31});
    @(posedge mdc); t0 = $time; @(posedge mdc);
    check(($time - t0) == 40, "R12 mdc period 2*(div+1) clocks", 64'($time - t0), 64'd40);
    waitIdle();
    hostRead(13, v);
    check(v == {22'd0, 5'd5, 5'd3}, "R11 write during busy ignored", 64'(v), 64'({5'd5, 5'd3}));
    check(mdc == 1'b0, "R12 mdc low when idle", 64'(mdc), 64'd0);

    // R4 Clause 22 read
    expectRead(2'b01, 2'b10, 5'd1, 5'd2, 1, 16'h1234, "R4 c22 read header");
    hostWrite(13, {16'd0, 1'b1, 5'd0, 5'd1, 5'd2});
    waitIdle();
    hostRead(14, v);
    check(v == 32'h0000_1234, "R4 read data captured", 64'(v), 64'h1234);
    hostRead(12, v);
    check(v[1] == 1'b0, "R9 no error on answered read", 64'(v[1]), 64'd0);

    // R7 preamble disable
    hostWrite(13, {21'd0, 1'b1, 5'd7, 5'd9});
    expectFrame(mkFrame(2'b01, 2'b01, 5'd7, 5'd9, 16'h0F0F), 0, "R7 no preamble frame");
    hostWrite(14, 32'h0000_0F0F);
    waitIdle();

    // R5 Clause 45 address frame, R10 no data busy
    hostWrite(12, 32'h0000_0140);
    hostWrite(13, {22'd0, 5'd2, 5'd1});
    expectFrame(mkFrame(2'b00, 2'b00, 5'd2, 5'd1, 16'h0100), 1, "R5 c45 address frame");
    hostWrite(15, 32'h0000_0100);
    hostRead(14, v);
    check(v[31] == 1'b0, "R10 data busy clear during address frame", 64'(v[31]), 64'd0);
    hostRead(12, v);
    check(v[0] == 1'b1, "R10 status busy during address frame", 64'(v[0]), 64'd1);
    waitIdle();

    // R6 Clause 45 write, read, post-increment read
    expectFrame(mkFrame(2'b00, 2'b01, 5'd2, 5'd1, 16'hBEEF), 1, "R6 c45 write frame");
    hostWrite(14, 32'h0000_BEEF);
    waitIdle();
    expectRead(2'b00, 2'b11, 5'd2, 5'd1, 1, 16'hCAFE, "R6 c45 read header");
    hostWrite(13, {16'd0, 1'b1, 5'd0, 5'd2, 5'd1});
    waitIdle();
    hostRead(14, v);
    check(v[15:0] == 16'hCAFE, "R6 c45 read data", 64'(v[15:0]), 64'hCAFE);
    expectRead(2'b00, 2'b10, 5'd2, 5'd1, 1, 16'h8001, "R6 c45 post-increment read header");
    hostWrite(13, {16'd0, 2'b11, 4'd0, 5'd2, 5'd1});
    waitIdle();
    hostRead(14, v);
    check(v[15:0] == 16'h8001, "R6 post-increment read data", 64'(v[15:0]), 64'h8001);

    // R9 read error then clear
    expectRead(2'b00, 2'b11, 5'd4, 5'd4, 0, 16'h0000, "R9 silent read header");
    hostWrite(13, {16'd0, 1'b1, 5'd0, 5'd4, 5'd4});
    waitIdle();
    hostRead(12, v);
    check(v[1] == 1'b1, "R9 read error set", 64'(v[1]), 64'd1);
    expectRead(2'b00, 2'b11, 5'd4, 5'd4, 1, 16'h0042, "R9 recovery read header");
    hostWrite(13, {16'd0, 1'b1, 5'd0, 5'd4, 5'd4});
    waitIdle();
    hostRead(12, v);
    check(v[1] == 1'b0, "R9 read error cleared by next read", 64'(v[1]), 64'd0);

    // R5 Clause 22 address write sends nothing
    hostWrite(12, 32'h0000_0100);
    hostWrite(15, 32'h0000_5555);
    repeat (4) @(negedge clk);
    hostRead(12, v);
    check(v[0] == 1'b0, "R5 no frame for c22 address write", 64'(v[0]), 64'd0);
    hostRead(15, v);
    check(v == 32'h0000_5555, "R5 address stored", 64'(v), 64'h5555);

    check(q.size() == 0, "R3 all expected frames observed", 64'(q.size()), 64'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule